// File: doc/BRIEF.md
# Glitch-free two-source system clock switch

This block drives the system clock from one of two free-running sources, a crystal-derived clock or an external frequency input. Each source runs at twice the processor's internal clock rate. The choice between them can change while the system is running, for example to drop to a slower clock for low power and to return to full speed later. The select input is a plain level that software or board logic may change at any time. The block watches that level, parks the output low at a safe point in the output cycle, and then brings the output back on the new source without ever emitting a shortened pulse.

The handover follows a fixed sequence. The select is read only during output cycles in which the peripheral clock is high. After a change is seen, the output stops low on the second peripheral-clock fall that follows. The new source then takes over after two of its own edges. The crystal path is passed through in phase. The external path is passed through inverted, so on that path the output rises on falling edges of the external clock. No frequency ratio between the sources is assumed, so either may be faster and the ratio need not be an integer.

Top module: `clk_src_switch`

## Requirements
- R1: With select at 0 the output follows the crystal clock: same period, and it rises on crystal rising edges. With select at 1 the output follows the inverted external clock: same period, and it rises on external falling edges.
- R2: While reset is low the output stays low. After reset is released, with select held steady, the output starts on the selected source without a handover and without any pulse from the other source.
- R3: The two source paths are never enabled together, and the output never carries a high pulse shorter than a high phase of the source in use.
- R4: The select level passes a two-stage synchronizer and is then compared at output falling edges where the peripheral clock is high. Once a change is seen, the output is frozen low at the output falling edge where the second following peripheral-clock fall is observed. Between 3 and 8 output rising edges occur after the select change and before the freeze.
- R5: When the crystal takes over, its path is enabled on the second crystal falling edge after the freeze, and the output next rises on a crystal rising edge. The low gap lasts between 1 and 3 crystal periods.
- R6: When the external source takes over, its path is enabled on the second external rising edge after the freeze, and the output next rises on an external falling edge. The low gap lasts between 1 and 3 external periods.
- R7: Handover works for any ratio between the source frequencies, including an external source slower than the crystal at a non-integer ratio (18 ns against 8 ns).
- R8: A select change that arrives while a handover is in progress is held. It is acted on only after the new source has restarted and the old path has acknowledged the handover. A reversal made mid-handover therefore yields two complete handovers and ends on the last selected source.
- R9: A path's enable changes only while that path's local clock is low: the crystal while it is low, the external clock while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Free-running crystal-derived source clock |
| ext_clk | input | 1 | Free-running external frequency source clock |
| sel | input | 1 | Asynchronous source select: 0 crystal, 1 external |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk | input | 1 | Current peripheral-clock level, half the output rate |
| sys_clk | output | 1 | Gated system clock output |

## Verification
The checks assume that both sources keep running and that the peripheral-clock input toggles on output rising edges, so that its level alternates at successive output falling edges. They also assume that the select is steady around reset release. The bench generates the peripheral clock from the output itself and holds the select constant across each reset. It changes the select and reset only at times away from any source edge. The external period is changed only while the crystal drives the output.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int unsigned NUM_SRC  = 2;
    localparam logic        SEL_XTAL = 1'b0;
    localparam logic        SEL_EXT  = 1'b1;

    // per-path handover state, advanced at local-clock falling edges
    typedef enum logic [1:0] {
        CS_OFF,   // path gated off, waiting for a start request
        CS_RUN,   // path drives the output, watching the select
        CS_ARM0,  // change seen, no peripheral fall yet
        CS_ARM1   // one peripheral fall seen, next one parks the output
    } cell_state_e;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksw_cell.sv
module clksw_cell
    import clksw_pkg::*;
#(
    parameter logic        MY_SEL      = 1'b0,
    parameter bit          INVERT      = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic sel,
    input  logic pclk,
    input  logic peer_rel,
    input  logic peer_en,
    output logic en,
    output logic rel,
    output logic gclk
);
    localparam int unsigned REQ_STAGES = SYNC_STAGES - 1;
    localparam int unsigned BOOT_AT    = SYNC_STAGES;
    localparam int unsigned BW         = $clog2(BOOT_AT + 2);

    // samp_clk rises where the local (passed-through) clock falls
    logic samp_clk;
    assign samp_clk = INVERT ? src_clk : ~src_clk;

    logic sel_s, req_s, pen_s;

    clksw_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
        .clk(samp_clk), .rst_n(rst_n), .d(sel), .q(sel_s));
    // the enable flop below is the last stage of the start synchronizer
    clksw_sync #(.STAGES(REQ_STAGES)) u_req_sync (
        .clk(samp_clk), .rst_n(rst_n), .d(peer_rel), .q(req_s));
    clksw_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(samp_clk), .rst_n(rst_n), .d(peer_en), .q(pen_s));

    cell_state_e   st;
    logic          pclk_q;
    logic [BW-1:0] boot_cnt;
    logic          boot_req, change_seen, pfall;

    assign boot_req    = (boot_cnt == BW'(BOOT_AT)) && (sel_s == MY_SEL);
    assign change_seen = (sel_s != MY_SEL) && pclk && !req_s && !rel;
    assign pfall       = fell(pclk_q, pclk);

    always_ff @(posedge samp_clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= CS_OFF;
            en       <= 1'b0;
            rel      <= 1'b0;
            pclk_q   <= 1'b0;
            boot_cnt <= '0;
        end else begin
            pclk_q <= pclk;
            if (boot_cnt != BW'(BOOT_AT + 1)) boot_cnt <= boot_cnt + BW'(1);
            if (rel && pen_s) rel <= 1'b0;
            unique case (st)
                CS_OFF: if (req_s || boot_req) begin
                    en <= 1'b1;
                    st <= CS_RUN;
                end
                CS_RUN:  if (change_seen) st <= CS_ARM0;
                CS_ARM0: if (pfall) st <= CS_ARM1;
                CS_ARM1: if (pfall) begin
                    en  <= 1'b0;
                    rel <= 1'b1;
                    st  <= CS_OFF;
                end
                default: st <= CS_OFF;
            endcase
        end
    end

    // enable only moves while the local clock is low, so no runt can pass
    assign gclk = ~samp_clk & en;
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import clksw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic xtal_clk,
    input  logic ext_clk,
    input  logic sel,
    input  logic rst_n,
    input  logic pclk,
    output logic sys_clk
);
    logic [NUM_SRC-1:0] src_vec, en_vec, rel_vec, gclk_vec;

    assign src_vec = {ext_clk, xtal_clk};

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_path
            clksw_cell #(
                .MY_SEL      (1'(i)),
                .INVERT      (i == 1),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_cell (
                .src_clk  (src_vec[i]),
                .rst_n    (rst_n),
                .sel      (sel),
                .pclk     (pclk),
                .peer_rel (rel_vec[NUM_SRC-1-i]),
                .peer_en  (en_vec[NUM_SRC-1-i]),
                .en       (en_vec[i]),
                .rel      (rel_vec[i]),
                .gclk     (gclk_vec[i])
            );
        end
    endgenerate

    assign sys_clk = |gclk_vec;
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker (
    input logic       xtal_clk,
    input logic       ext_clk,
    input logic       rst_n,
    input logic       sys_clk,
    input logic [1:0] en_vec
);
    // R3: the two paths are never enabled together
    a_r3_single_path: assert property (@(posedge xtal_clk) disable iff (!rst_n)
        !(en_vec[0] && en_vec[1]));

    // R1: every output rise comes from the enabled path's own rising edge
    always @(posedge sys_clk) begin
        if (rst_n) begin
            a_r1_rise_source: assert ((en_vec[0] && xtal_clk) || (en_vec[1] && !ext_clk));
        end
    end

    // R2: no output pulse while reset is held
    always @(posedge sys_clk) begin
        a_r2_quiet_reset: assert (rst_n);
    end

    // R9: enables move only while their local clock is low
    always @(en_vec[0]) begin
        if (rst_n) begin
            a_r9_xtal_en_low: assert (!xtal_clk);
        end
    end

    always @(en_vec[1]) begin
        if (rst_n) begin
            a_r9_ext_en_low: assert (ext_clk);
        end
    end
endmodule

bind clk_src_switch clksw_checker u_clksw_checker (
    .xtal_clk (xtal_clk),
    .ext_clk  (ext_clk),
    .rst_n    (rst_n),
    .sys_clk  (sys_clk),
    .en_vec   (en_vec)
);

// File: tb/tb_clk_src_switch.sv
module tb_clk_src_switch;
    timeunit 1ns;
    timeprecision 100ps;

    logic xtal_clk = 1'b0;
    logic ext_clk  = 1'b0;
    logic sel      = 1'b0;
    logic rst_n    = 1'b0;
    logic pclk     = 1'b0;
    logic sys_clk;
    int   ext_half = 7;

    localparam int XT_PER = 8;   // 125 MHz crystal
    // {select, external half period}
    localparam logic [4:0] VEC [6] = '{5'h17, 5'h07, 5'h19, 5'h09, 5'h17, 5'h07};

    always #4 xtal_clk = ~xtal_clk;
    always #(ext_half) ext_clk = ~ext_clk;

    always @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) pclk <= 1'b0;
        else        pclk <= ~pclk;
    end

    clk_src_switch dut (
        .xtal_clk (xtal_clk),
        .ext_clk  (ext_clk),
        .sel      (sel),
        .rst_n    (rst_n),
        .pclk     (pclk),
        .sys_clk  (sys_clk)
    );

    int n_chk = 0;
    int n_err = 0;

    // output monitor, sampling 0.5 ns after each whole ns
    int   now_ns = 0, rise_cnt = 0, last_rise = 0, period = 0;
    int   low_run = 0, high_run = 0, gap_cnt = 0, last_gap = 0;
    int   gap_rise_idx = 0, runt_cnt = 0;
    logic prev_sys = 1'b0, gap_x = 1'b0, gap_e = 1'b0;

    initial begin
        #0.5;
        forever begin
            if (sys_clk === 1'b1 && prev_sys === 1'b0) begin
                rise_cnt++;
                period    = now_ns - last_rise;
                last_rise = now_ns;
                if (low_run > 10) begin
                    gap_cnt++;
                    last_gap     = low_run;
                    gap_rise_idx = rise_cnt;
                    gap_x        = xtal_clk;
                    gap_e        = ext_clk;
                end
                low_run  = 0;
                high_run = 0;
            end
            if (sys_clk === 1'b0 && prev_sys === 1'b1) begin
                if (high_run < 3) runt_cnt++;
                high_run = 0;
            end
            if (sys_clk === 1'b1) high_run++;
            else                  low_run++;
            prev_sys = sys_clk;
            now_ns++;
            #1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int g0, rc0, rn0, old, t;
        logic vs;
        logic [3:0] vh;
        #0.3;
        // R2: silent during reset, then start on crystal
        #100;
        chk(rise_cnt == 0, "R2", "rises during reset", rise_cnt, 0);
        rst_n = 1'b1;
        #200;
        chk(period == XT_PER, "R2", "period after reset", period, XT_PER);
        chk(gap_x == 1'b1, "R1", "first rise on crystal edge", int'(gap_x), 1);

        for (int v = 0; v < 6; v++) begin
            {vs, vh} = VEC[v];
            ext_half = int'(vh);
            g0  = gap_cnt;
            rc0 = rise_cnt;
            rn0 = runt_cnt;
            sel = vs;
            #300;
            t = vs ? 2 * int'(vh) : XT_PER;
            chk(gap_cnt - g0 == 1, vs ? "R6" : "R5", "handover count", gap_cnt - g0, 1);
            chk(period == t, "R1", "period on new source", period, t);
            if (vs && vh == 4'd9)
                chk(period == 18, "R7", "slow non-integer source period", period, 18);
            old = gap_rise_idx - 1 - rc0;
            chk(old >= 3 && old <= 8, "R4", "pulses before freeze", old, 8);
            chk(last_gap >= t && last_gap <= 3 * t + 1, vs ? "R6" : "R5",
                "parked low length", last_gap, 3 * t);
            if (vs) chk(gap_e == 1'b0, "R6", "restart on external fall", int'(gap_e), 0);
            else    chk(gap_x == 1'b1, "R5", "restart on crystal rise", int'(gap_x), 1);
            chk(runt_cnt == rn0, "R3", "short high pulses", runt_cnt - rn0, 0);
        end

        // R8: reversal during a handover is held, then handled
        g0 = gap_cnt;
        rn0 = runt_cnt;
        sel = 1'b1;
        #45;
        sel = 1'b0;
        #600;
        chk(gap_cnt - g0 == 2, "R8", "handovers after reversal", gap_cnt - g0, 2);
        chk(period == XT_PER, "R8", "final source period", period, XT_PER);
        chk(runt_cnt == rn0, "R3", "short pulses across reversal", runt_cnt - rn0, 0);

        // R2: reset with external selected starts on external directly
        rst_n = 1'b0;
        #20;
        sel = 1'b1;
        rc0 = rise_cnt;
        #50;
        chk(rise_cnt == rc0, "R2", "rises during second reset", rise_cnt - rc0, 0);
        rst_n = 1'b1;
        #200;
        chk(gap_rise_idx == rc0 + 1, "R2", "first rise index after reset",
            gap_rise_idx - rc0, 1);
        chk(gap_e == 1'b0, "R2", "first rise on external fall", int'(gap_e), 0);
        chk(period == 2 * ext_half, "R2", "period after reset on external",
            period, 2 * ext_half);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule